// File: doc/BRIEF.md
# Acquisition Run Sequencer

This block paces data taking for a group of front-end readout boards. After a start command it arms the boards and opens an acquisition window once the beam-present level is high. It then hands over to readout when the window closes. Two modes share the one sequencer, and the mode is chosen when a run leaves idle. In beam-test mode the window closes on a rising edge of an external trigger or on a memory-full report, and each readout is followed by a timed flush of the front-end chips. In ILC mode only memory-full closes the window, and there is no flush.

A run is either continuous or single. A continuous run returns to the arm stage after every readout. A single run drops back to idle. Stop and reset commands bring the block to idle at once. In ILC mode the sequence can also be frozen and released. A busy level tells a common board that this detector is in a run, so several detectors can be kept in step. The trigger and beam inputs are asynchronous and are resynchronised inside the block.

Top module: `acq_sequencer`

## Requirements
- R1: After rst_n low, or one cycle after cmd_reset, busy, acq_en, readout_req and flush are all 0. cmd_reset also clears a pending pause.
- R2: A start command in idle raises busy on the next cycle. acq_en rises only when the beam level is 1, three cycles after beam_async rises (two synchroniser flops plus the state register). While beam is 0 the block waits with busy=1 and acq_en=0.
- R3: In beam-test mode (mode_ilc=0 when the run starts), readout_req replaces acq_en three cycles after a rising edge of trig_async, or one cycle after mem_full. A trigger held high ends only one window.
- R4: In ILC mode (mode_ilc=1 when the run starts), the trigger has no effect, and mem_full moves the block from acquisition to readout one cycle later.
- R5: readout_req stays high until readout_done. In beam-test mode flush is then high for exactly FLUSH_CYCLES cycles. In ILC mode flush never rises.
- R6: After a run started by cmd_start_loop, the block goes back to the arm stage (busy=1, acq_en=0) at the end of each readout or flush. After a run started by cmd_start_once, it goes to idle.
- R7: cmd_stop returns the block to idle on the next cycle from any state, even while paused. A stop arriving together with a start in idle leaves the block idle.
- R8: cmd_pause given while mode_ilc=1 freezes the state and all outputs until cmd_resume. Inputs that arrive during the freeze are not acted on. A pause given while mode_ilc=0 has no effect.
- R9: busy is 1 in every state except idle, and at most one of acq_en, readout_req and flush is 1.
- R10: Changing mode_ilc during a run does not change that run's behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ilc | input | 1 | 1 selects ILC mode, 0 selects beam-test mode; taken at run start |
| cmd_start_loop | input | 1 | Start a continuous run (one-cycle pulse) |
| cmd_start_once | input | 1 | Start a single run (one-cycle pulse) |
| cmd_stop | input | 1 | Stop the run and go idle |
| cmd_pause | input | 1 | Freeze the sequencer (ILC mode only) |
| cmd_resume | input | 1 | Release a freeze |
| cmd_reset | input | 1 | Force idle and clear the pause |
| trig_async | input | 1 | Asynchronous external trigger |
| beam_async | input | 1 | Asynchronous beam-present level, 1 = beam |
| mem_full | input | 1 | Front-end memory full, synchronous |
| readout_done | input | 1 | Front-end readout finished, synchronous |
| acq_en | output | 1 | Acquisition window open |
| readout_req | output | 1 | Readout requested |
| flush | output | 1 | Front-end flush in progress |
| busy | output | 1 | Block is in a run |

## Verification
On every cycle the assertions check four things. The three stage outputs are mutually exclusive and agree with busy. Stop and reset reach idle in one cycle. The state holds while a pause is pending. A readout starts only from acquisition, and a flush follows only a beam-test readout. The bench scenarios cover what a single-cycle property cannot see. These are the three-cycle latency of the beam and trigger synchronisers, the edge-only response to a trigger held high, and the exact flush length. The bench also shows loop versus single endings and that the mode is latched at run start. It sweeps every mix of mode, start kind and window-closing cause.

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int FLUSH_CYCLES = 4,
  parameter bit BEAM_GATE    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_ilc,
  input  logic cmd_start_loop,
  input  logic cmd_start_once,
  input  logic cmd_stop,
  input  logic cmd_pause,
  input  logic cmd_resume,
  input  logic cmd_reset,
  input  logic trig_async,
  input  logic beam_async,
  input  logic mem_full,
  input  logic readout_done,
  output logic acq_en,
  output logic readout_req,
  output logic flush,
  output logic busy
);
  localparam int CW = $clog2(FLUSH_CYCLES + 1);
  localparam logic [CW-1:0] FLUSH_LAST = CW'(FLUSH_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_ACQ, S_READ, S_FLUSH} seq_t;

  seq_t st, st_n;
  logic [CW-1:0] fcnt;
  logic loop_q, ilc_q, paused_q;
  logic trig_s1, trig_s2, trig_d, beam_s1, beam_s2;
  logic trig_evt, beam_ok, start_ok;

  initial if (FLUSH_CYCLES < 1) $error("FLUSH_CYCLES must be at least 1");

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {trig_s1, trig_s2, trig_d, beam_s1, beam_s2} <= '0;
    end else begin
      trig_s1 <= trig_async;
      trig_s2 <= trig_s1;
      trig_d  <= trig_s2;
      beam_s1 <= beam_async;
      beam_s2 <= beam_s1;
    end
  end

  assign trig_evt = trig_s2 & ~trig_d;
  assign beam_ok  = !BEAM_GATE || beam_s2;
  assign start_ok = (st == S_IDLE) && !paused_q && !cmd_stop && !cmd_reset &&
                    (cmd_start_loop || cmd_start_once);

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE:  if (cmd_start_loop || cmd_start_once) st_n = S_ARM;
      S_ARM:   if (beam_ok) st_n = S_ACQ;
      S_ACQ:   if (mem_full || (!ilc_q && trig_evt)) st_n = S_READ;
      S_READ:  if (readout_done) st_n = ilc_q ? (loop_q ? S_ARM : S_IDLE) : S_FLUSH;
      S_FLUSH: if (fcnt == FLUSH_LAST) st_n = loop_q ? S_ARM : S_IDLE;
      default: st_n = S_IDLE;
    endcase
    if (paused_q) st_n = st;
    if (cmd_stop || cmd_reset) st_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      fcnt     <= '0;
      loop_q   <= 1'b0;
      ilc_q    <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      st <= st_n;
      if (st != S_FLUSH)  fcnt <= '0;
      else if (!paused_q) fcnt <= fcnt + 1'b1;
      if (cmd_reset || cmd_stop) loop_q <= 1'b0;
      else if (start_ok)         loop_q <= cmd_start_loop;
      if (start_ok) ilc_q <= mode_ilc;
      if (cmd_reset || cmd_resume)  paused_q <= 1'b0;
      else if (cmd_pause && mode_ilc) paused_q <= 1'b1;
    end
  end

  assign acq_en      = (st == S_ACQ);
  assign readout_req = (st == S_READ);
  assign flush       = (st == S_FLUSH);
  assign busy        = (st != S_IDLE);

  // R9
  stage_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acq_en, readout_req, flush}));
  // R9
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en || readout_req || flush) |-> busy);
  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !busy);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> !busy);
  // R8
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_q && !cmd_stop && !cmd_reset) |=> (st == $past(st)));
  // R3
  read_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(readout_req) |-> $past(acq_en));
  // R5
  flush_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |-> ($past(readout_req) && !ilc_q));
endmodule

// File: tb/acq_sequencer_tb_top.sv
module acq_sequencer_tb_top;
  localparam int FLUSH = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_ilc = 0, c_loop = 0, c_once = 0, c_stop = 0, c_pause = 0, c_resume = 0, c_reset = 0;
  logic trig = 0, beam = 1, mfull = 0, rdone = 0;
  logic acq_en, readout_req, flush, busy;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  acq_sequencer #(.FLUSH_CYCLES(FLUSH), .BEAM_GATE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ilc(mode_ilc),
    .cmd_start_loop(c_loop), .cmd_start_once(c_once), .cmd_stop(c_stop),
    .cmd_pause(c_pause), .cmd_resume(c_resume), .cmd_reset(c_reset),
    .trig_async(trig), .beam_async(beam), .mem_full(mfull), .readout_done(rdone),
    .acq_en(acq_en), .readout_req(readout_req), .flush(flush), .busy(busy));

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int outs();
    return {busy, acq_en, readout_req, flush};
  endfunction

  task automatic pulse_start(input logic lp);
    if (lp) c_loop = 1; else c_once = 1;
    tick();
    c_loop = 0; c_once = 0;
  endtask

  task automatic pulse_stop();
    c_stop = 1; tick(); c_stop = 0;
  endtask

  // Starts in acquisition; ends the window, reads out, flushes and checks the ending.
  task automatic run_one(input logic ilc, input logic use_trig, input logic lp);
    int fl;
    if (use_trig) begin
      trig = 1;
      tick(2);
      chk("R3 acq held before trig sync", acq_en, 1);
      tick();
      if (ilc) begin
        tick();
        chk("R4 trig ignored in ilc", {acq_en, readout_req}, 2'b10);
        trig = 0;
      end else begin
        chk("R3 trig edge to readout", {acq_en, readout_req}, 2'b01);
        trig = 0;
      end
    end
    if (!readout_req) begin
      mfull = 1; tick(); mfull = 0;
      chk(ilc ? "R4 memfull to readout" : "R3 memfull to readout", {acq_en, readout_req}, 2'b01);
    end
    tick(3);
    chk("R5 readout held", readout_req, 1);
    rdone = 1; tick(); rdone = 0;
    fl = 0;
    while (flush && fl < 100) begin fl++; tick(); end
    chk("R5 flush length", fl, ilc ? 0 : FLUSH);
    chk("R6 ending", outs(), lp ? 4'b1000 : 4'b0000);
    if (lp) begin
      tick();
      chk("R6 loop reacquires", acq_en, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 reset outputs", outs(), 0);
    rst_n = 1;
    tick(3);
    chk("R1 idle after reset", outs(), 0);

    // R10 sweep: mode flipped after start; the latched mode governs the run.
    for (int m = 0; m < 2; m++)
      for (int lp = 0; lp < 2; lp++)
        for (int tc = 0; tc < 2; tc++) begin
          mode_ilc = m[0];
          pulse_start(lp[0]);
          chk("R2 arm after start", outs(), 4'b1000);
          mode_ilc = ~m[0];
          tick();
          chk("R2 acq with beam", acq_en, 1);
          for (int it = 0; it < (lp ? 2 : 1); it++) run_one(m[0], tc[0], lp[0]);
          if (lp) begin
            pulse_stop();
            chk("R7 stop to idle", outs(), 0);
          end
          tick(4);
        end

    // R2 beam gate latency
    beam = 0; mode_ilc = 0;
    tick(4);
    pulse_start(1'b0);
    tick(4);
    chk("R2 wait for beam", outs(), 4'b1000);
    beam = 1;
    tick(2);
    chk("R2 beam not yet synced", acq_en, 0);
    tick();
    chk("R2 beam synced", acq_en, 1);
    run_one(1'b0, 1'b0, 1'b0);

    // R3 trigger held high ends only one window
    pulse_start(1'b1);
    tick();
    trig = 1;
    tick(3);
    chk("R3 first edge", readout_req, 1);
    tick();
    rdone = 1; tick(); rdone = 0;
    tick(FLUSH + 1);
    chk("R3 held trig no retrigger", {acq_en, readout_req}, 2'b10);
    tick(6);
    chk("R3 held trig still acq", acq_en, 1);
    trig = 0;
    pulse_stop();
    chk("R7 stop from acq", outs(), 0);

    // R8 pause in ilc mode freezes
    mode_ilc = 1;
    pulse_start(1'b1);
    tick();
    c_pause = 1; tick(); c_pause = 0;
    mfull = 1; tick(); mfull = 0;
    tick(3);
    chk("R8 frozen in acq", outs(), 4'b1100);
    c_resume = 1; tick(); c_resume = 0;
    tick(2);
    chk("R8 released still acq", acq_en, 1);
    mfull = 1; tick(); mfull = 0;
    chk("R8 memfull after resume", readout_req, 1);
    c_pause = 1; tick(); c_pause = 0;
    rdone = 1; tick(); rdone = 0;
    chk("R8 done ignored while frozen", outs(), 4'b1010);
    // R7 stop overrides pause, pause stays pending
    pulse_stop();
    chk("R7 stop while paused", outs(), 0);
    pulse_start(1'b0);
    chk("R8 start frozen in idle", busy, 0);
    c_reset = 1; tick(); c_reset = 0;
    chk("R1 cmd_reset idle", outs(), 0);
    pulse_start(1'b0);
    chk("R1 reset cleared pause", busy, 1);
    pulse_stop();

    // R8 pause in beam-test mode ignored
    mode_ilc = 0;
    pulse_start(1'b0);
    tick();
    c_pause = 1; tick(); c_pause = 0;
    mfull = 1; tick(); mfull = 0;
    chk("R8 pause ignored in beam-test", readout_req, 1);
    pulse_stop();

    // R7 stop with start in idle
    c_stop = 1; c_loop = 1; tick(); c_stop = 0; c_loop = 0;
    chk("R7 stop beats start", busy, 0);
    // R1 cmd_reset mid run
    pulse_start(1'b1);
    tick();
    c_reset = 1; tick(); c_reset = 0;
    chk("R1 reset mid run", outs(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule